// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the bus-facing controller of a serial memory that sits on a two-wire bus as a slave. It runs on a fast system clock. It oversamples the clock line and data line through synchronizers and finds start and stop conditions on the synchronized copies. It shifts bytes in and out and matches the slave address against three device-select pins. It drives the acknowledge bit by asserting an open-drain pull-down enable.

The engine handles single-byte and multi-byte writes, current-address reads, random reads and sequential reads. It has no array and no address counter of its own. Instead it sends a load request and an increment strobe to an external word-address counter. It takes read data from that counter's location. It sends a byte strobe to a page buffer and a start pulse to the write-cycle controller. While that controller reports busy, the engine does not acknowledge, so a master can poll for completion.

Top module: `twi_mem_slave`

## Requirements
- R1: After a synchronous reset the pull-down enable is low and no load, increment, byte or write-start strobe is active.
- R2: The first byte after a start is acknowledged (pull-down during the ninth clock) only when bit 7 is 1 and bits 6..4 equal the select pins XOR `SEL_INV` (default 3'b010, so bit 5 matches the inverted middle pin). On a mismatch the engine stays silent and ignores later bytes until the next start.
- R3: While `busy_i` is high, a matching address byte is not acknowledged.
- R4: After a write-mode address, the next byte is acknowledged and one load request is issued with value {address bits 3..1, that byte}.
- R5: Every later byte in write mode is acknowledged and produces one byte strobe carrying it and one increment strobe.
- R6: A stop after at least one data byte produces one single-cycle write-start pulse. A stop after only an address or word address produces none.
- R7: After a read-mode address (bit 0 = 1), the engine sends `rd_data_i` MSB first, one bit per clock. It releases the line for the ninth clock and pulses the increment strobe once per byte. Address bits 3..1 of a read-mode address do not load the counter.
- R8: A low ninth bit from the master continues with the next byte. A high ninth bit ends driving until the next start.
- R9: A start seen in any state aborts the transfer and returns to address reception, so a repeated start gives a random read.
- R10: The pull-down enable changes only while the clock line is low, and the load, byte and write-start strobes are never active together.
- R11: A repeated start after write data abandons that data: the following stop issues no write-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sel_i | input | 3 | Device-select pins |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Byte at the current counter location |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| addr_ld_o | output | 1 | Load request for the word-address counter |
| addr_val_o | output | 11 | Word address to load |
| addr_inc_o | output | 1 | Increment strobe for the counter |
| pbuf_we_o | output | 1 | Page-buffer byte strobe |
| pbuf_data_o | output | 8 | Byte for the page buffer |
| wcyc_start_o | output | 1 | Start pulse for the write cycle |

## Verification
The assertions watch, on every cycle, that the pull-down enable moves only while the clock line is low. They also check that a write-start pulse lasts one cycle and lands while the clock is high, as a stop requires, that the strobes stay exclusive, and that no acknowledge begins while busy is high. The bench scenarios show the rest: which address bytes earn an acknowledge for every select-pin setting, the load value and byte order of writes, the read data sequence with its increment, the effect of the master's ninth bit, and whether a stop or repeated start results in a write cycle.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int DATA_W = 8;
    localparam int HI_W   = 3;
    localparam int SEL_W  = 3;
    localparam int WA_W   = HI_W + DATA_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } twi_state_e;

    typedef struct packed {
        logic             one;
        logic [SEL_W-1:0] sel;
        logic [HI_W-1:0]  hi;
        logic             rd;
    } addr_byte_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic dev_match(addr_byte_t ab, logic [SEL_W-1:0] pins,
                                       logic [SEL_W-1:0] inv);
        return ab.one && (ab.sel == (pins ^ inv));
    endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output line_ev_t ev
);
    logic [STAGES-1:0][1:0] chain;
    logic [1:0]             prev;
    logic [1:0]             cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 2'b11;
        end else begin
            chain <= {chain[STAGES-2:0], {scl_raw, sda_raw}};
            prev  <= chain[STAGES-1];
        end
    end

    assign cur = chain[STAGES-1];

    always_comb begin
        ev.sda      = cur[0];
        ev.scl_rise = cur[1] & ~prev[1];
        ev.scl_fall = ~cur[1] & prev[1];
        ev.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
        ev.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    end
endmodule

// File: rtl/twi_addr_cmp.sv
module twi_addr_cmp
    import twi_pkg::*;
#(
    parameter logic [SEL_W-1:0] SEL_INV = 3'b010
) (
    input  addr_byte_t       abyte_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);
    assign hit_o = dev_match(abyte_i, sel_i, SEL_INV);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [SEL_W-1:0] SEL_INV     = 3'b010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic              addr_ld_o,
    output logic [WA_W-1:0]   addr_val_o,
    output logic              addr_inc_o,
    output logic              pbuf_we_o,
    output logic [DATA_W-1:0] pbuf_data_o,
    output logic              wcyc_start_o
);
    localparam logic [CNT_W-1:0] RX_DONE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(DATA_W - 1);

    line_ev_t          ev;
    twi_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic [HI_W-1:0]   hi_q;
    logic              rd_mode;
    logic              rd_cont;
    logic              have_data;
    logic              hit;
    addr_byte_t        ab;

    assign ab = addr_byte_t'(sh);

    twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .ev      (ev)
    );

    twi_addr_cmp #(.SEL_INV(SEL_INV)) i_cmp (
        .abyte_i (ab),
        .sel_i   (sel_i),
        .hit_o   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            sh           <= '0;
            hi_q         <= '0;
            rd_mode      <= 1'b0;
            rd_cont      <= 1'b0;
            have_data    <= 1'b0;
            sda_pull_o   <= 1'b0;
            addr_ld_o    <= 1'b0;
            addr_val_o   <= '0;
            addr_inc_o   <= 1'b0;
            pbuf_we_o    <= 1'b0;
            pbuf_data_o  <= '0;
            wcyc_start_o <= 1'b0;
        end else begin
            addr_ld_o    <= 1'b0;
            addr_inc_o   <= 1'b0;
            pbuf_we_o    <= 1'b0;
            wcyc_start_o <= 1'b0;
            if (ev.stop) begin
                state        <= ST_IDLE;
                sda_pull_o   <= 1'b0;
                wcyc_start_o <= have_data;
                have_data    <= 1'b0;
            end else if (ev.start) begin
                state      <= ST_ADDR;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
                have_data  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WORD, ST_WDATA: begin
                        if (ev.scl_rise && cnt != RX_DONE) begin
                            sh  <= {sh[DATA_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == RX_DONE) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (hit && !busy_i) begin
                                    sda_pull_o <= 1'b1;
                                    rd_mode    <= ab.rd;
                                    hi_q       <= ab.hi;
                                    state      <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WORD) begin
                                sda_pull_o <= 1'b1;
                                addr_ld_o  <= 1'b1;
                                addr_val_o <= {hi_q, sh};
                                state      <= ST_WORD_ACK;
                            end else begin
                                sda_pull_o  <= 1'b1;
                                pbuf_we_o   <= 1'b1;
                                pbuf_data_o <= sh;
                                addr_inc_o  <= 1'b1;
                                have_data   <= 1'b1;
                                state       <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                sh         <= rd_data_i;
                                sda_pull_o <= ~rd_data_i[DATA_W-1];
                                state      <= ST_RDATA;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_WORD;
                            end
                        end
                    end
                    ST_WORD_ACK, ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (cnt == TX_LAST) begin
                                sda_pull_o <= 1'b0;
                                addr_inc_o <= 1'b1;
                                cnt        <= '0;
                                state      <= ST_RACK;
                            end else begin
                                sh         <= {sh[DATA_W-2:0], 1'b0};
                                sda_pull_o <= ~sh[DATA_W-2];
                                cnt        <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            rd_cont <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (rd_cont) begin
                                sh         <= rd_data_i;
                                sda_pull_o <= ~rd_data_i[DATA_W-1];
                                state      <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic busy_i,
    input logic sda_pull_o,
    input logic addr_ld_o,
    input logic pbuf_we_o,
    input logic wcyc_start_o
);
    p_pull_rise_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_i);

    p_pull_fall_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull_o) |-> !scl_i);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_ld_o, pbuf_we_o, wcyc_start_o}));

    p_wstart_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        wcyc_start_o |=> !wcyc_start_o);

    p_wstart_at_stop_r6: assert property (@(posedge clk) disable iff (rst)
        wcyc_start_o |-> scl_i);

    p_ld_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        addr_ld_o |=> !addr_ld_o);

    // R3: an acknowledge never starts while the write cycle is busy
    p_busy_silent_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !busy_i);
endmodule

bind twi_mem_slave twi_mem_slave_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .busy_i       (busy_i),
    .sda_pull_o   (sda_pull_o),
    .addr_ld_o    (addr_ld_o),
    .pbuf_we_o    (pbuf_we_o),
    .wcyc_start_o (wcyc_start_o)
);

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  sel = 3'b000;
    logic        busy = 1'b0;
    logic [7:0]  rd_data;
    logic        sda_pull;
    logic        addr_ld;
    logic [10:0] addr_val;
    logic        addr_inc;
    logic        pbuf_we;
    logic [7:0]  pbuf_data;
    logic        wcyc_start;
    logic        sda_line;

    int errors = 0;
    int checks = 0;
    int ld_cnt = 0, we_cnt = 0, inc_cnt = 0, wc_cnt = 0;
    logic [7:0]  last_we;
    logic [10:0] last_ld;
    logic [10:0] ba;
    bit          done = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    twi_mem_slave i_twi_mem_slave (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sel_i        (sel),
        .busy_i       (busy),
        .rd_data_i    (rd_data),
        .sda_pull_o   (sda_pull),
        .addr_ld_o    (addr_ld),
        .addr_val_o   (addr_val),
        .addr_inc_o   (addr_inc),
        .pbuf_we_o    (pbuf_we),
        .pbuf_data_o  (pbuf_data),
        .wcyc_start_o (wcyc_start)
    );

    function automatic logic [7:0] memf(logic [10:0] a);
        return (a[7:0] * 8'd37) ^ {a[10:8], 5'h0b};
    endfunction

    assign rd_data = memf(ba);

    always @(posedge clk) begin
        if (rst) begin
            ba <= '0;
        end else begin
            if (addr_ld) begin ld_cnt++; last_ld = addr_val; ba <= addr_val; end
            else if (addr_inc) ba <= ba + 11'd1;
            if (addr_inc) inc_cnt++;
            if (pbuf_we) begin we_cnt++; last_we = pbuf_data; end
            if (wcyc_start) wc_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        acked = !sda_line;
        tick(Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q / 2);
            d[i] = sda_line;
            tick(Q / 2);
            scl_m = 1'b0;
        end
        tick(2);
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        int         wc0;
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        chk(!sda_pull && !addr_ld && !addr_inc && !pbuf_we && !wcyc_start,
            "R1 reset outputs", {sda_pull, addr_ld, addr_inc, pbuf_we, wcyc_start}, 0);

        // R2 sweep of select pins against address fields
        for (int s = 0; s < 8; s++) begin
            for (int f = 0; f < 8; f++) begin
                sel = 3'(s);
                wc0 = wc_cnt;
                bus_start();
                send_byte({1'b1, 3'(f), 3'b000, 1'b0}, ack);
                chk(ack == (3'(f) == (3'(s) ^ 3'b010)), "R2 address match", ack,
                    (3'(f) == (3'(s) ^ 3'b010)));
                bus_stop();
                chk(wc_cnt == wc0, "R6 no write after address only", wc_cnt, wc0);
            end
            bus_start();
            send_byte({1'b0, 3'(s) ^ 3'b010, 3'b000, 1'b0}, ack);
            chk(!ack, "R2 leading bit zero", ack, 0);
            bus_stop();
        end

        // R2 bytes after a mismatch are ignored
        sel = 3'b101;
        bus_start();
        send_byte(8'h80, ack);
        chk(!ack, "R2 mismatch nack", ack, 0);
        send_byte(8'h12, ack);
        chk(!ack && we_cnt == 0 && ld_cnt == 0, "R2 later byte ignored", {ack, 8'(we_cnt)}, 0);
        bus_stop();

        // R4 R5 R6 page write: field 111, high bits 110, word 5A
        bus_start();
        send_byte(8'hFC, ack);
        chk(ack, "R4 address ack", ack, 1);
        send_byte(8'h5A, ack);
        chk(ack && ld_cnt == 1 && last_ld == 11'h65A, "R4 word load", last_ld, 11'h65A);
        for (int k = 1; k <= 3; k++) begin
            send_byte(8'(k * 17), ack);
            chk(ack && we_cnt == k && inc_cnt == k && last_we == 8'(k * 17),
                "R5 data byte strobe", last_we, k * 17);
        end
        chk(wc_cnt == 0, "R6 no write before stop", wc_cnt, 0);
        bus_stop();
        tick(2);
        chk(wc_cnt == 1, "R6 write start at stop", wc_cnt, 1);

        // R3 busy: no acknowledge
        busy = 1'b1;
        bus_start();
        send_byte(8'hFC, ack);
        chk(!ack, "R3 busy nack", ack, 0);
        bus_stop();
        busy = 1'b0;
        chk(wc_cnt == 1 && ld_cnt == 1, "R3 busy no effect", wc_cnt, 1);

        // R9 R7 R8 random read at 0x310
        bus_start();
        send_byte(8'hF6, ack);
        send_byte(8'h10, ack);
        chk(ack && last_ld == 11'h310, "R9 dummy write load", last_ld, 11'h310);
        bus_start();
        send_byte(8'hF7, ack);
        chk(ack, "R9 read address ack after repeated start", ack, 1);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k != 2, d);
            chk(d == memf(11'h310 + 11'(k)), "R7 sequential read data", d,
                memf(11'h310 + 11'(k)));
        end
        chk(ld_cnt == 2, "R7 read address loads nothing", ld_cnt, 2);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R8 silent after master nack", d, 8'hFF);
        bus_stop();
        tick(2);
        chk(wc_cnt == 1, "R6 dummy write starts no cycle", wc_cnt, 1);

        // R7 current-address read continues at 0x313
        bus_start();
        send_byte(8'hF1, ack);
        recv_byte(1'b0, d);
        chk(ack && d == memf(11'h313), "R7 current address read", d, memf(11'h313));
        bus_stop();

        // R11 start abandons write data; R5 increment visible to next read
        bus_start();
        send_byte(8'hFC, ack);
        send_byte(8'h00, ack);
        send_byte(8'h44, ack);
        chk(ack && last_we == 8'h44, "R5 single data byte", last_we, 8'h44);
        bus_start();
        send_byte(8'hF7, ack);
        recv_byte(1'b0, d);
        chk(d == memf(11'h601), "R5 increment after write byte", d, memf(11'h601));
        bus_stop();
        tick(2);
        chk(wc_cnt == 1, "R11 abandoned write", wc_cnt, 1);
        chk(!sda_pull, "R10 released after transfers", sda_pull, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule